// File: doc/BRIEF.md
# Display register command-stream executor

This block replays a queue of register-programming instructions held in memory. Software fills the queue and loads a start (head) byte address and an end (tail) byte address. It then raises the enable level. The block fetches each two-dword instruction through a synchronous read port, decodes it and carries it out. Register writes leave on an address, data and byte-lane write port. Waits are counted on a microsecond strobe or on vertical-blank pulses, and an interrupt instruction gives a single-cycle pulse. The block only writes registers and never reads them.

A run can be held back until the next vertical blank. A halt level stops it cleanly between instructions. `busy` is high for the whole run, and `cur_head` gives the byte address of the instruction being worked on. An indexed burst carries a count followed by that many data dwords, all sent to one register offset. The instruction after an odd-length burst begins after one pad dword, so every instruction starts on an 8-byte boundary. The tail must sit on a 64-byte line boundary.

Top module: `cse_exec`

## Requirements
- R1: While reset is held and just after it, `busy`, `wr_valid` and `irq_pulse` are 0 and `cur_head` is 0.
- R2: An instruction is a low dword at an 8-byte-aligned byte address followed by a high dword at that address plus 4. The high dword carries the opcode in bits 31:24, the byte-lane enables in bits 23:20 and the register offset in bits 19:0. Opcode 0x01 issues one write of the low dword to that offset, with `wr_be` equal to the enable field. Instructions execute in memory order.
- R3: Opcode 0x09 takes the low 16 bits of its low dword as a count N. It issues N writes with `wr_be` = 4'b1111 to its offset, using the N following dwords in order. N = 0 issues nothing. No data dword at or beyond the tail is fetched, and the run ends there.
- R4: After a burst with odd N, one pad dword is skipped whatever it holds, and the next instruction is taken from the following 8-byte boundary.
- R5: Opcode 0x02 stalls the queue until as many `usec_tick` pulses as the low 16 bits of its low dword have arrived. A count of 0 does not stall.
- R6: Opcode 0x04 stalls the queue in the same way, counting `vblank_pulse` pulses.
- R7: Opcode 0x07 produces exactly one single-cycle `irq_pulse` per instruction.
- R8: Opcodes 0x00, 0x03, 0x05, 0x06, 0x0A and every undefined opcode issue no write and no interrupt, and execution continues with the next instruction.
- R9: With the block idle and the tail a multiple of 64 bytes, raising `ctl_enable` sets `busy` on the next cycle. `busy` stays high until the tail is reached. A tail that is not line-aligned never starts a run. Writes appear only while `busy` is high.
- R10: If `ctl_vbl_wait` is high when the run starts, nothing executes until a `vblank_pulse` arrives.
- R11: While `ctl_halt` is high, the run ends at the next instruction boundary. `cur_head` then points at the first instruction not executed.
- R12: `cur_head` is always 8-byte aligned. It shows the instruction being executed, and it equals the tail once a run has completed.
- R13: A finished run does not restart while `ctl_enable` stays high. Dropping `ctl_enable` while idle clears `cur_head` to 0 and re-arms the block.
- R14: Every read address presented is below the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Start level; drop while idle to re-arm |
| ctl_vbl_wait | input | 1 | Hold the start until a vertical blank |
| ctl_halt | input | 1 | Stop at the next instruction boundary |
| head_addr | input | ADDR_W | Byte address of the first instruction |
| tail_addr | input | ADDR_W | Byte address where execution ends, 64-byte aligned |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_addr | output | ADDR_W | Byte address of the dword to read |
| mem_rd_data | input | 32 | Read dword, valid the cycle after the strobe |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte-lane enables |
| usec_tick | input | 1 | Microsecond strobe |
| vblank_pulse | input | 1 | Vertical-blank pulse |
| irq_pulse | output | 1 | Single-cycle interrupt |
| busy | output | 1 | Run in progress |
| cur_head | output | ADDR_W | Byte address of the current instruction |

## Verification
The checker watches, on every cycle, the rules that hold state by state. Writes happen only while busy, and bursts always use full byte lanes. The interrupt lasts one cycle, reads stay below the tail, and the current head stays aligned. Stalls hold until their strobe arrives, and dropping enable while idle clears the head. Only the bench scenarios can show that the whole write sequence is correct. That covers sweeps over every byte-enable value and every burst length from 0 to 9, the skipping of odd pads and unknown opcodes, exact strobe counts on waits, and the point at which a halted run stops.

// File: rtl/cse_pkg.sv
package cse_pkg;

  localparam int REG_W      = 20;
  localparam int INS_BYTES  = 8;
  localparam int LINE_BYTES = 64;
  localparam int N_WAITS    = 2;
  localparam int WAIT_US_IDX = 0;
  localparam int WAIT_VB_IDX = 1;

  localparam logic [7:0] OP_NOP      = 8'h00;
  localparam logic [7:0] OP_WRITE    = 8'h01;
  localparam logic [7:0] OP_WAIT_US  = 8'h02;
  localparam logic [7:0] OP_WAIT_VBL = 8'h04;
  localparam logic [7:0] OP_IRQ      = 8'h07;
  localparam logic [7:0] OP_BURST    = 8'h09;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VBL, ST_FETCH_LO, ST_FETCH_HI, ST_EXEC,
    ST_BURST_RD, ST_BURST_WR, ST_WAIT_US, ST_WAIT_VBL
  } seq_state_e;

  typedef struct packed {
    logic [7:0]       op;
    logic [3:0]       be;
    logic [REG_W-1:0] reg_off;
  } hi_word_t;

  function automatic hi_word_t split_hi(input logic [31:0] w);
    return hi_word_t'(w);
  endfunction

  function automatic logic line_aligned(input logic [31:0] a);
    return (a & 32'(LINE_BYTES - 1)) == 32'd0;
  endfunction

  // next instruction after a burst of n data dwords starting at base
  function automatic logic [31:0] after_burst(input logic [31:0] base,
                                              input logic [31:0] n);
    return base + 32'(INS_BYTES) + (((n + 32'd1) >> 1) << 3);
  endfunction

endpackage

// File: rtl/cse_tick_cnt.sv
module cse_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         active,
  output logic         done
);
  logic [W-1:0] cnt_q;

  assign done = active && tick && (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (active && tick)  cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/cse_wr_stage.sv
module cse_wr_stage
  import cse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [REG_W-1:0] issue_addr,
  input  logic [31:0]      issue_data,
  input  logic [3:0]       issue_be,
  input  logic             irq_issue,
  output logic             wr_valid,
  output logic [REG_W-1:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic [3:0]       wr_be,
  output logic             irq_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_be     <= '0;
      irq_pulse <= 1'b0;
    end else begin
      wr_valid  <= issue;
      irq_pulse <= irq_issue;
      if (issue) begin
        wr_addr <= issue_addr;
        wr_data <= issue_data;
        wr_be   <= issue_be;
      end
    end
  end
endmodule

// File: rtl/cse_seq.sv
module cse_seq
  import cse_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 16,
  parameter int WAIT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_vbl_wait,
  input  logic              ctl_halt,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [ADDR_W-1:0] tail_addr,
  input  logic              vblank_pulse,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic [N_WAITS-1:0] cnt_load,
  output logic [N_WAITS-1:0] cnt_active,
  output logic [WAIT_W-1:0] cnt_val,
  input  logic [N_WAITS-1:0] cnt_done,
  output logic              wr_issue,
  output logic [REG_W-1:0]  wr_issue_addr,
  output logic [31:0]       wr_issue_data,
  output logic [3:0]        wr_issue_be,
  output logic              irq_issue,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_head,
  output logic [ADDR_W-1:0] tail_q,
  output logic              ev_burst_wr,
  output logic              in_vbl_gate
);
  localparam logic [ADDR_W-1:0] STEP_INS = ADDR_W'(INS_BYTES);
  localparam logic [ADDR_W-1:0] STEP_DW  = ADDR_W'(4);

  seq_state_e state_q, state_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d, dptr_q, dptr_d, tail_d;
  logic [31:0]        lo_q, lo_d;
  logic [BURST_W-1:0] remain_q, remain_d, bcount_q, bcount_d;
  logic [REG_W-1:0]   breg_q, breg_d;
  logic               spent_q, spent_d;
  hi_word_t           hi_w;
  logic               stop_now;
  logic [BURST_W-1:0] lo_count;
  logic [WAIT_W-1:0]  lo_wait;
  logic [ADDR_W-1:0]  burst_next;

  assign hi_w       = split_hi(mem_rd_data);
  assign stop_now   = ctl_halt || (ptr_q >= tail_q);
  assign lo_count   = lo_q[BURST_W-1:0];
  assign lo_wait    = lo_q[WAIT_W-1:0];
  assign burst_next = ADDR_W'(after_burst(32'(ptr_q), 32'(bcount_q)));
  assign busy       = (state_q != ST_IDLE);
  assign cur_head   = ptr_q;
  assign cnt_val    = lo_wait;
  assign ev_burst_wr = (state_q == ST_BURST_WR);
  assign in_vbl_gate = (state_q == ST_VBL);
  assign cnt_active[WAIT_US_IDX] = (state_q == ST_WAIT_US);
  assign cnt_active[WAIT_VB_IDX] = (state_q == ST_WAIT_VBL);

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    dptr_d   = dptr_q;
    tail_d   = tail_q;
    lo_d     = lo_q;
    remain_d = remain_q;
    bcount_d = bcount_q;
    breg_d   = breg_q;
    spent_d  = spent_q;
    mem_rd_en     = 1'b0;
    mem_rd_addr   = ptr_q;
    cnt_load      = '0;
    wr_issue      = 1'b0;
    wr_issue_addr = hi_w.reg_off;
    wr_issue_data = lo_q;
    wr_issue_be   = hi_w.be;
    irq_issue     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (!ctl_enable) begin
          spent_d = 1'b0;
          ptr_d   = '0;
        end else if (!spent_q) begin
          spent_d = 1'b1;
          if (line_aligned(32'(tail_addr))) begin
            ptr_d   = {head_addr[ADDR_W-1:3], 3'b000};
            tail_d  = tail_addr;
            state_d = ctl_vbl_wait ? ST_VBL : ST_FETCH_LO;
          end
        end
      end
      ST_VBL: begin
        if (vblank_pulse) state_d = ST_FETCH_LO;
      end
      ST_FETCH_LO: begin
        if (stop_now) begin
          state_d = ST_IDLE;
        end else begin
          mem_rd_en = 1'b1;
          state_d   = ST_FETCH_HI;
        end
      end
      ST_FETCH_HI: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = ptr_q + STEP_DW;
        lo_d        = mem_rd_data;
        state_d     = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH_LO;
        ptr_d   = ptr_q + STEP_INS;
        case (hi_w.op)
          OP_WRITE: wr_issue = 1'b1;
          OP_IRQ:   irq_issue = 1'b1;
          OP_BURST: begin
            if (lo_count != '0) begin
              ptr_d    = ptr_q;
              dptr_d   = ptr_q + STEP_INS;
              remain_d = lo_count;
              bcount_d = lo_count;
              breg_d   = hi_w.reg_off;
              state_d  = ST_BURST_RD;
            end
          end
          OP_WAIT_US: begin
            if (lo_wait != '0) begin
              ptr_d = ptr_q;
              cnt_load[WAIT_US_IDX] = 1'b1;
              state_d = ST_WAIT_US;
            end
          end
          OP_WAIT_VBL: begin
            if (lo_wait != '0) begin
              ptr_d = ptr_q;
              cnt_load[WAIT_VB_IDX] = 1'b1;
              state_d = ST_WAIT_VBL;
            end
          end
          default: ;
        endcase
      end
      ST_BURST_RD: begin
        if (dptr_q >= tail_q) begin
          ptr_d   = tail_q;
          state_d = ST_IDLE;
        end else begin
          mem_rd_en   = 1'b1;
          mem_rd_addr = dptr_q;
          state_d     = ST_BURST_WR;
        end
      end
      ST_BURST_WR: begin
        wr_issue      = 1'b1;
        wr_issue_addr = breg_q;
        wr_issue_data = mem_rd_data;
        wr_issue_be   = 4'hF;
        dptr_d        = dptr_q + STEP_DW;
        remain_d      = remain_q - BURST_W'(1);
        if (remain_q == BURST_W'(1)) begin
          ptr_d   = burst_next;
          state_d = ST_FETCH_LO;
        end else begin
          state_d = ST_BURST_RD;
        end
      end
      ST_WAIT_US: begin
        if (cnt_done[WAIT_US_IDX]) begin
          ptr_d   = ptr_q + STEP_INS;
          state_d = ST_FETCH_LO;
        end
      end
      ST_WAIT_VBL: begin
        if (cnt_done[WAIT_VB_IDX]) begin
          ptr_d   = ptr_q + STEP_INS;
          state_d = ST_FETCH_LO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      dptr_q   <= '0;
      tail_q   <= '0;
      lo_q     <= '0;
      remain_q <= '0;
      bcount_q <= '0;
      breg_q   <= '0;
      spent_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      dptr_q   <= dptr_d;
      tail_q   <= tail_d;
      lo_q     <= lo_d;
      remain_q <= remain_d;
      bcount_q <= bcount_d;
      breg_q   <= breg_d;
      spent_q  <= spent_d;
    end
  end
endmodule

// File: rtl/cse_exec.sv
module cse_exec
  import cse_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 16,
  parameter int WAIT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_vbl_wait,
  input  logic              ctl_halt,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [ADDR_W-1:0] tail_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              wr_valid,
  output logic [19:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  input  logic              usec_tick,
  input  logic              vblank_pulse,
  output logic              irq_pulse,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_head
);
  logic [N_WAITS-1:0] cnt_load, cnt_active, cnt_done, cnt_tick;
  logic [WAIT_W-1:0]  cnt_val;
  logic               wr_issue, irq_issue;
  logic [REG_W-1:0]   wr_issue_addr;
  logic [31:0]        wr_issue_data;
  logic [3:0]         wr_issue_be;
  logic [ADDR_W-1:0]  tail_q;
  logic               ev_burst_wr, in_vbl_gate;
  logic               in_wait_us, in_wait_vbl;

  assign cnt_tick[WAIT_US_IDX] = usec_tick;
  assign cnt_tick[WAIT_VB_IDX] = vblank_pulse;
  assign in_wait_us  = cnt_active[WAIT_US_IDX];
  assign in_wait_vbl = cnt_active[WAIT_VB_IDX];

  cse_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctl_enable(ctl_enable), .ctl_vbl_wait(ctl_vbl_wait), .ctl_halt(ctl_halt),
    .head_addr(head_addr), .tail_addr(tail_addr), .vblank_pulse(vblank_pulse),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .cnt_load(cnt_load), .cnt_active(cnt_active), .cnt_val(cnt_val), .cnt_done(cnt_done),
    .wr_issue(wr_issue), .wr_issue_addr(wr_issue_addr), .wr_issue_data(wr_issue_data),
    .wr_issue_be(wr_issue_be), .irq_issue(irq_issue),
    .busy(busy), .cur_head(cur_head), .tail_q(tail_q),
    .ev_burst_wr(ev_burst_wr), .in_vbl_gate(in_vbl_gate)
  );

  for (genvar gi = 0; gi < N_WAITS; gi++) begin : g_wait
    cse_tick_cnt #(.W(WAIT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load[gi]), .load_val(cnt_val),
      .tick(cnt_tick[gi]), .active(cnt_active[gi]), .done(cnt_done[gi])
    );
  end

  cse_wr_stage u_wr (
    .clk(clk), .rst_n(rst_n), .issue(wr_issue), .issue_addr(wr_issue_addr),
    .issue_data(wr_issue_data), .issue_be(wr_issue_be), .irq_issue(irq_issue),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .irq_pulse(irq_pulse)
  );
endmodule

// File: rtl/cse_exec_chk.sv
module cse_exec_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_enable,
  input logic              busy,
  input logic              wr_valid,
  input logic [3:0]        wr_be,
  input logic              irq_pulse,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [ADDR_W-1:0] tail_q,
  input logic [ADDR_W-1:0] cur_head,
  input logic              ev_burst_wr,
  input logic              in_wait_us,
  input logic              usec_tick,
  input logic              in_wait_vbl,
  input logic              vblank_pulse,
  input logic              in_vbl_gate
);
  // R9
  wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
  // R9
  busy_from_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_enable));
  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R14
  rd_below_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr < tail_q));
  // R12
  head_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_head[2:0] == 3'b000);
  // R13
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_enable && !busy) |=> (cur_head == '0));
  // R5
  us_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait_us && !usec_tick) |=> (in_wait_us && !wr_valid));
  // R6
  vbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait_vbl && !vblank_pulse) |=> (in_wait_vbl && !wr_valid));
  // R10
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vbl_gate && !vblank_pulse) |=> (in_vbl_gate && !wr_valid));
  // R3
  burst_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_burst_wr |=> (wr_valid && wr_be == 4'hF));
endmodule

bind cse_exec cse_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .busy(busy),
  .wr_valid(wr_valid), .wr_be(wr_be), .irq_pulse(irq_pulse),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .tail_q(tail_q),
  .cur_head(cur_head), .ev_burst_wr(ev_burst_wr), .in_wait_us(in_wait_us),
  .usec_tick(usec_tick), .in_wait_vbl(in_wait_vbl), .vblank_pulse(vblank_pulse),
  .in_vbl_gate(in_vbl_gate)
);

// File: tb/sim_cse_exec.sv
module sim_cse_exec;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_enable = 1'b0, ctl_vbl_wait = 1'b0, ctl_halt = 1'b0;
  logic [AW-1:0] head_addr = '0, tail_addr = '0;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic wr_valid;
  logic [19:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_be;
  logic usec_tick = 1'b0, vblank_pulse = 1'b0;
  logic irq_pulse, busy;
  logic [AW-1:0] cur_head;

  always #2 clk = ~clk;

  cse_exec #(.ADDR_W(AW)) u0 (.*);

  logic [31:0] mem [512];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[10:2]];

  logic [55:0] exp_q[$];
  logic [55:0] got_q[$];
  int n_chk = 0, n_fail = 0, irq_cnt = 0, rd_bad = 0, wp = 0;
  bit done_flag = 0;

  always @(negedge clk) begin
    if (wr_valid) got_q.push_back({wr_addr, wr_be, wr_data});
    if (irq_pulse) irq_cnt++;
    if (mem_rd_en && mem_rd_addr >= tail_addr) rd_bad++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic put(input logic [31:0] lo, input logic [31:0] hi);
    mem[wp] = lo; mem[wp+1] = hi; wp += 2;
  endtask
  task automatic begin_prog(input int dw);
    wp = dw; exp_q.delete(); got_q.delete(); irq_cnt = 0; rd_bad = 0;
  endtask
  task automatic wr1(input logic [19:0] r, input logic [3:0] be, input logic [31:0] d);
    put(d, {8'h01, be, r}); exp_q.push_back({r, be, d});
  endtask
  task automatic burst(input logic [19:0] r, input int n, input logic [31:0] seed);
    put(n, {8'h09, 4'h0, r});
    for (int i = 0; i < n; i++) begin
      mem[wp] = seed + i * 32'h0101_0007; exp_q.push_back({r, 4'hF, seed + i * 32'h0101_0007}); wp++;
    end
    if (n % 2 == 1) begin mem[wp] = 32'hFFFF_FFFF; wp++; end
  endtask
  task automatic close_prog();
    while (wp % 16 != 0) begin mem[wp] = 32'h0; wp++; end
    tail_addr = AW'(wp * 4);
  endtask
  task automatic start(input int head, input bit vbl, input string req);
    head_addr = AW'(head); ctl_vbl_wait = vbl; ctl_enable = 1'b1;
    cyc(1);
    chk(busy == 1'b1, req, busy, 1);
  endtask
  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin cyc(1); n++; end
    chk(!busy, req, busy, 0);
    cyc(2);
  endtask
  task automatic stop();
    ctl_enable = 1'b0; ctl_vbl_wait = 1'b0; cyc(2);
  endtask
  task automatic cmp_writes(input string req);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
  endtask
  task automatic pulse_us(); usec_tick = 1'b1; cyc(1); usec_tick = 1'b0; cyc(3); endtask
  task automatic pulse_vb(); vblank_pulse = 1'b1; cyc(1); vblank_pulse = 1'b0; cyc(3); endtask

  initial begin
    cyc(3);
    // R1 during reset
    chk(!busy && !wr_valid && !irq_pulse && cur_head == 0, "R1", {busy, wr_valid, irq_pulse}, 0);
    rst_n = 1'b1; cyc(2);
    chk(!busy && !wr_valid && !irq_pulse && cur_head == 0, "R1", cur_head, 0);

    // R2: every byte-enable value, head not line aligned
    begin_prog(18);
    for (int b = 0; b < 16; b++) wr1(20'h00100 + b, 4'(b), 32'h1111_1111 * b ^ 32'hA5A5_0000);
    wr1(20'hFFFFF, 4'hF, 32'hCAFE_F00D);
    close_prog();
    start(18 * 4, 0, "R9");
    wait_idle("R9");
    cmp_writes("R2");
    chk(cur_head == tail_addr, "R12", cur_head, tail_addr);
    chk(rd_bad == 0, "R14", rd_bad, 0);
    // R13: held enable does not restart
    cyc(10);
    chk(!busy && got_q.size() == 17, "R13", got_q.size(), 17);
    stop();
    chk(cur_head == 0, "R13", cur_head, 0);

    // R3 / R4: burst lengths 0..9, each followed by a single write
    for (int n = 0; n < 10; n++) begin
      begin_prog(0);
      burst(20'h02000 + n, n, 32'h1000_0000 * n + 32'h77);
      wr1(20'h03000 + n, 4'hF, 32'hBEEF_0000 + n);
      close_prog();
      start(0, 0, "R9");
      wait_idle("R3");
      cmp_writes((n % 2 == 1) ? "R4" : "R3");
      chk(rd_bad == 0, "R14", rd_bad, 0);
      stop();
    end

    // R3: burst cut off by the tail
    begin_prog(0);
    burst(20'h04444, 40, 32'h5);
    tail_addr = 16'd64;
    exp_q.delete();
    for (int i = 0; i < 14; i++) exp_q.push_back({20'h04444, 4'hF, 32'h5 + i * 32'h0101_0007});
    start(0, 0, "R9");
    wait_idle("R3");
    cmp_writes("R3");
    chk(cur_head == 16'd64, "R3", cur_head, 64);
    chk(rd_bad == 0, "R14", rd_bad, 0);
    stop();

    // R8: skipped opcodes, R7: interrupts
    begin_prog(32);
    put(32'h1234, {8'h03, 4'hF, 20'h00111});
    put(32'h1234, {8'h05, 4'hF, 20'h00112});
    put(32'h1234, {8'h06, 4'hF, 20'h00113});
    put(32'h1234, {8'h0A, 4'hF, 20'h00114});
    put(32'h1234, {8'h00, 4'hF, 20'h00115});
    put(32'h1234, {8'h0B, 4'hF, 20'h00116});
    put(32'h1234, {8'hFF, 4'hF, 20'h00117});
    wr1(20'h00999, 4'h3, 32'h0000_5A5A);
    close_prog();
    start(128, 0, "R9");
    wait_idle("R8");
    cmp_writes("R8");
    chk(irq_cnt == 0, "R8", irq_cnt, 0);
    stop();

    begin_prog(0);
    put(0, {8'h07, 24'h0}); put(0, {8'h07, 24'h0}); put(0, {8'h07, 24'h0});
    wr1(20'h00777, 4'hF, 32'h7);
    close_prog();
    start(0, 0, "R9");
    wait_idle("R7");
    chk(irq_cnt == 3, "R7", irq_cnt, 3);
    cmp_writes("R7");
    stop();

    // R5: microsecond wait of 3, then of 0
    begin_prog(0);
    wr1(20'h00A01, 4'hF, 32'hA);
    put(3, {8'h02, 24'h0});
    wr1(20'h00A02, 4'hF, 32'hB);
    put(0, {8'h02, 24'h0});
    wr1(20'h00A03, 4'hF, 32'hC);
    close_prog();
    start(0, 0, "R9");
    cyc(40);
    chk(busy && got_q.size() == 1, "R5", got_q.size(), 1);
    chk(cur_head == 16'd8, "R12", cur_head, 8);
    pulse_us(); pulse_us(); cyc(20);
    chk(got_q.size() == 1, "R5", got_q.size(), 1);
    pulse_us();
    wait_idle("R5");
    cmp_writes("R5");
    stop();

    // R6: vblank wait of 2
    begin_prog(0);
    put(2, {8'h04, 24'h0});
    wr1(20'h00B01, 4'hF, 32'hB1);
    close_prog();
    start(0, 0, "R9");
    cyc(30); pulse_vb(); cyc(20);
    chk(busy && got_q.size() == 0, "R6", got_q.size(), 0);
    pulse_vb();
    wait_idle("R6");
    cmp_writes("R6");
    stop();

    // R10: start gated on vblank
    begin_prog(0);
    wr1(20'h00C01, 4'h5, 32'hC1);
    close_prog();
    start(0, 1, "R9");
    cyc(30);
    chk(busy && got_q.size() == 0, "R10", got_q.size(), 0);
    pulse_vb();
    wait_idle("R10");
    cmp_writes("R10");
    stop();

    // R9: unaligned tail never starts
    begin_prog(0);
    wr1(20'h00D01, 4'hF, 32'hD1);
    close_prog();
    tail_addr = 16'd32;
    head_addr = 0; ctl_enable = 1'b1; cyc(20);
    chk(!busy && got_q.size() == 0, "R9", {busy, 8'(got_q.size())}, 0);
    stop();

    // R11: halt mid-run
    begin_prog(0);
    for (int i = 0; i < 24; i++) wr1(20'h00E00 + i, 4'hF, 32'hE000 + i);
    close_prog();
    start(0, 0, "R9");
    while (got_q.size() < 3) cyc(1);
    ctl_halt = 1'b1;
    wait_idle("R11");
    chk(got_q.size() < 24, "R11", got_q.size(), 23);
    chk(got_q.size() * 8 == cur_head, "R11", cur_head, got_q.size() * 8);
    for (int i = 0; i < got_q.size(); i++) chk(got_q[i] == exp_q[i], "R11", got_q[i], exp_q[i]);
    ctl_halt = 1'b0;
    stop();
    chk(cur_head == 0, "R13", cur_head, 0);

    // R13: re-armed block runs the same queue again
    got_q.delete();
    start(0, 0, "R13");
    wait_idle("R13");
    cmp_writes("R13");
    stop();

    report();
  end
endmodule